// File: doc/BRIEF.md
# SPI Master with Packing Byte Queues

This block is a serial peripheral interface master controlled through four 16-bit registers on 32-bit-aligned slots. Software writes outgoing data into a data register that feeds a four-byte transmit queue. The number of bytes that one write places in the queue depends on the configured frame size and on the write's byte strobes. A byte-lane write in 8-bit frame mode queues one frame. A full-width write in that mode queues two frames, low byte first. In 16-bit frame mode every write queues one 16-bit frame.

The shift engine takes whole frames off the queue. It clocks them out in SPI mode 0, most significant bit first. In loopback it collects the returning bits into a four-byte receive queue. Reads of the data register take one or two bytes off the receive queue, depending on the read's byte strobes. A status register reports transmit room, receive availability against a programmable threshold, and bus activity.

Register slots, selected by address bits [3:2]:
- Slot 0 (0x0): bit 0 enable, bits [DIV_BITS:1] clock exponent.
- Slot 1 (0x4): bit 0 frame width (0 means 8-bit, 1 means 16-bit), bit 1 receive threshold (1 means one byte, 0 means two bytes).
- Slot 2 (0x8): read-only status. Bit 0 transmit room, bit 1 receive ready, bit 2 busy.
- Slot 3 (0xC): data.

Top module: `spi_pack_master`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, both control slots read 0, and status reads 3'b001 (room, not ready, idle).
- R2: In 8-bit mode, a data write with strobes 2'b11 queues two frames. The frame from wdata[7:0] goes out first, then the frame from wdata[15:8], for 16 serial clocks in total.
- R3: In 8-bit mode, a data write with a single strobe queues exactly one frame, taken from the strobed lane, for 8 serial clocks.
- R4: In 16-bit mode, any data write with a nonzero strobe queues one 16-bit frame, shifted out as wdata[15] first, for 16 clocks.
- R5: A data write is discarded whole when the transmit queue lacks room for all the bytes it would add.
- R6: Status bit 0 is 1 exactly when the transmit queue's free byte count is at least the frame size in bytes.
- R7: Status bit 1 is 1 when the receive queue holds at least one byte (threshold bit 1) or at least two bytes (threshold bit 0).
- R8: A data read with strobes 2'b11 removes two bytes, the older byte in rdata[7:0]. A single-strobe read removes one byte, presented in the strobed lane. Missing bytes read as zero and remove nothing.
- R9: Each serial clock half period lasts 2^exponent system clocks. The output data bit changes only while the serial clock is low. Input data is captured on the rising serial clock edge.
- R10: Chip select stays low across back-to-back frames. It rises exactly one half period after the last falling serial clock edge.
- R11: While enable is 0, no frame starts. Frames already queued start once enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access in this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte address; bits [3:2] pick the slot |
| reg_wdata | input | 16 | Write data |
| reg_be | input | 2 | Byte strobes (bit 0 = low lane) |
| reg_rdata | output | 16 | Read data for the addressed slot |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The queue assertions rely on two conditions: software changes the frame width only while the transmit queue is empty and the engine is idle, and it never reads more bytes than the receive queue reports. The bench changes the width and clock exponent only while enable is 0 and chip select is high. It drains the receive queue with single-byte reads before each new transfer. Loopback of serial data out into serial data in makes every received byte predictable.

// File: rtl/spim_pkg.sv
package spim_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_TAIL} eng_st_t;
   localparam logic [1:0] SLOT_CTRL1  = 2'd0;
   localparam logic [1:0] SLOT_CTRL2  = 2'd1;
   localparam logic [1:0] SLOT_STATUS = 2'd2;
   localparam logic [1:0] SLOT_DATA   = 2'd3;
endpackage

// File: rtl/spim_byte_fifo.sv
module spim_byte_fifo #(
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 push_n,
   input  logic [15:0]                push_bytes,
   input  logic [1:0]                 pop_n,
   output logic [$clog2(DEPTH):0]     level,
   output logic [7:0]                 head0,
   output logic [7:0]                 head1
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = AW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spim_byte_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wp, rp;

   always_ff @(posedge clk) begin
      if (push_n != 2'd0) mem[wp] <= push_bytes[7:0];
      if (push_n == 2'd2) mem[wp + AW'(1)] <= push_bytes[15:8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         wp    <= wp + AW'(push_n);
         rp    <= rp + AW'(pop_n);
         level <= level + LW'(push_n) - LW'(pop_n);
      end
   end

   assign head0 = mem[rp];
   assign head1 = mem[rp + AW'(1)];

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      LW'(push_n) <= LW'(DEPTH) - level);
   p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      LW'(pop_n) <= level);
endmodule

// File: rtl/spim_shift_engine.sv
module spim_shift_engine import spim_pkg::*; #(
   parameter int DIV_BITS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_ok,
   input  logic                wide,
   input  logic [DIV_BITS-1:0] div_exp,
   input  logic [15:0]         tx_word,
   input  logic                miso,
   output logic                take,
   output logic                rx_push,
   output logic [15:0]         rx_word,
   output logic                rx_wide,
   output logic                sclk,
   output logic                mosi,
   output logic                cs_n
);
   localparam int CNTW = (1 << DIV_BITS) - 1;

   eng_st_t         st_q;
   logic [CNTW-1:0] cnt_q;
   logic [CNTW:0]   lim_w;
   logic [15:0]     txsh_q, rxsh_q;
   logic [4:0]      bits_q;
   logic            wide_q, tick, last;

   always_comb begin
      lim_w = ((CNTW + 1)'(1) << div_exp) - (CNTW + 1)'(1);
      tick  = (cnt_q == lim_w[CNTW-1:0]);
      last  = (bits_q == 5'd1);
      take  = start_ok && (st_q == ST_IDLE || (st_q == ST_HIGH && tick && last));
      rx_push = (st_q == ST_HIGH) && tick && last;
   end

   assign rx_word = rxsh_q;
   assign rx_wide = wide_q;
   assign mosi    = txsh_q[15];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         txsh_q <= '0;
         rxsh_q <= '0;
         bits_q <= '0;
         wide_q <= 1'b0;
         sclk   <= 1'b0;
         cs_n   <= 1'b1;
      end else begin
         cnt_q <= (st_q == ST_IDLE || tick) ? '0 : cnt_q + CNTW'(1);
         if (take) begin
            txsh_q <= tx_word;
            bits_q <= wide ? 5'd16 : 5'd8;
            wide_q <= wide;
            cs_n   <= 1'b0;
         end
         unique case (st_q)
            ST_IDLE: if (take) st_q <= ST_LOW;
            ST_LOW: if (tick) begin
               sclk   <= 1'b1;
               rxsh_q <= {rxsh_q[14:0], miso};
               st_q   <= ST_HIGH;
            end
            ST_HIGH: if (tick) begin
               sclk <= 1'b0;
               if (!last) begin
                  txsh_q <= {txsh_q[14:0], 1'b0};
                  bits_q <= bits_q - 5'd1;
                  st_q   <= ST_LOW;
               end else begin
                  st_q <= take ? ST_LOW : ST_TAIL;
               end
            end
            ST_TAIL: if (tick) begin
               cs_n <= 1'b1;
               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   p_mosi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HIGH && !tick) |=> $stable(mosi));
   p_clock_inside_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !cs_n);
   p_release_after_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (!sclk && $past(!sclk)));
endmodule

// File: rtl/spi_pack_master.sv
module spi_pack_master import spim_pkg::*; #(
   parameter int FIFO_DEPTH = 4,
   parameter int DIV_BITS   = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_sel,
   input  logic        reg_wr,
   input  logic [3:0]  reg_addr,
   input  logic [15:0] reg_wdata,
   input  logic [1:0]  reg_be,
   output logic [15:0] reg_rdata,
   output logic        spi_sclk,
   output logic        spi_mosi,
   input  logic        spi_miso,
   output logic        spi_cs_n
);
   localparam int LW = $clog2(FIFO_DEPTH) + 1;

   if (DIV_BITS < 1 || DIV_BITS > 4) begin : g_bad_div
      $error("spi_pack_master: DIV_BITS must lie in 1..4");
   end

   logic                en_q, wide_q, rxq_q;
   logic [DIV_BITS-1:0] div_q;
   logic [1:0]          slot, tx_req, tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
   logic [1:0]          frame_need, rx_need, rd_want;
   logic [LW-1:0]       tx_lvl, rx_lvl, tx_free, rx_free;
   logic [7:0]          tx_h0, tx_h1, rx_h0, rx_h1, b0, b1;
   logic [15:0]         tx_push_d, tx_word, rx_word, data_rd;
   logic                wr_acc, rd_acc, dat_wr, dat_rd, frame_ok;
   logic                eng_take, eng_rx_push, eng_rx_wide;

   assign slot   = reg_addr[3:2];
   assign wr_acc = reg_sel && reg_wr;
   assign rd_acc = reg_sel && !reg_wr;
   assign dat_wr = wr_acc && slot == SLOT_DATA && reg_be != 2'b00;
   assign dat_rd = rd_acc && slot == SLOT_DATA && reg_be != 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         div_q  <= '0;
         wide_q <= 1'b0;
         rxq_q  <= 1'b0;
      end else if (wr_acc && reg_be[0]) begin
         if (slot == SLOT_CTRL1) begin
            en_q  <= reg_wdata[0];
            div_q <= reg_wdata[DIV_BITS:1];
         end else if (slot == SLOT_CTRL2) begin
            wide_q <= reg_wdata[0];
            rxq_q  <= reg_wdata[1];
         end
      end
   end

   always_comb begin
      tx_free    = LW'(FIFO_DEPTH) - tx_lvl;
      rx_free    = LW'(FIFO_DEPTH) - rx_lvl;
      frame_need = wide_q ? 2'd2 : 2'd1;
      tx_req     = wide_q ? 2'd2 : 2'(reg_be[0]) + 2'(reg_be[1]);
      tx_push_d  = (!wide_q && reg_be == 2'b10) ? {8'h00, reg_wdata[15:8]} : reg_wdata;
      tx_push_n  = (dat_wr && tx_free >= LW'(tx_req)) ? tx_req : 2'd0;
      frame_ok   = en_q && tx_lvl >= LW'(frame_need);
      tx_pop_n   = eng_take ? frame_need : 2'd0;
      tx_word    = wide_q ? {tx_h1, tx_h0} : {tx_h0, 8'h00};
      rx_need    = eng_rx_wide ? 2'd2 : 2'd1;
      rx_push_n  = (eng_rx_push && rx_free >= LW'(rx_need)) ? rx_need : 2'd0;
      rd_want    = (reg_be == 2'b11) ? 2'd2 : 2'd1;
      if (!dat_rd)                     rx_pop_n = 2'd0;
      else if (rx_lvl >= LW'(rd_want)) rx_pop_n = rd_want;
      else                             rx_pop_n = (rx_lvl != '0) ? 2'd1 : 2'd0;
      b0 = (rx_lvl != '0)       ? rx_h0 : 8'h00;
      b1 = (rx_lvl >= LW'(2))   ? rx_h1 : 8'h00;
      case (reg_be)
         2'b11:   data_rd = {b1, b0};
         2'b10:   data_rd = {b0, 8'h00};
         default: data_rd = {8'h00, b0};
      endcase
      reg_rdata = '0;
      case (slot)
         SLOT_CTRL1: begin
            reg_rdata[0]          = en_q;
            reg_rdata[DIV_BITS:1] = div_q;
         end
         SLOT_CTRL2: reg_rdata[1:0] = {rxq_q, wide_q};
         SLOT_STATUS: begin
            reg_rdata[0] = tx_free >= LW'(frame_need);
            reg_rdata[1] = rx_lvl >= (rxq_q ? LW'(1) : LW'(2));
            reg_rdata[2] = !spi_cs_n;
         end
         default: reg_rdata = data_rd;
      endcase
   end

   spim_byte_fifo #(.DEPTH(FIFO_DEPTH)) i_txq (
      .clk(clk), .rst_n(rst_n), .push_n(tx_push_n), .push_bytes(tx_push_d),
      .pop_n(tx_pop_n), .level(tx_lvl), .head0(tx_h0), .head1(tx_h1));

   spim_byte_fifo #(.DEPTH(FIFO_DEPTH)) i_rxq (
      .clk(clk), .rst_n(rst_n), .push_n(rx_push_n), .push_bytes(rx_word),
      .pop_n(rx_pop_n), .level(rx_lvl), .head0(rx_h0), .head1(rx_h1));

   spim_shift_engine #(.DIV_BITS(DIV_BITS)) i_eng (
      .clk(clk), .rst_n(rst_n), .start_ok(frame_ok), .wide(wide_q), .div_exp(div_q),
      .tx_word(tx_word), .miso(spi_miso), .take(eng_take), .rx_push(eng_rx_push),
      .rx_word(rx_word), .rx_wide(eng_rx_wide), .sclk(spi_sclk), .mosi(spi_mosi),
      .cs_n(spi_cs_n));

   p_drop_when_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && tx_free < LW'(tx_req)) |=> tx_lvl <= $past(tx_lvl));
   p_quiet_when_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && spi_cs_n) |=> spi_cs_n);
endmodule

// File: tb/test_spi_pack_master.sv
`timescale 1ns/1ps
module test_spi_pack_master;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_sel = 1'b0, reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [1:0]  reg_be = '0;
   logic [15:0] reg_rdata;
   logic        spi_sclk, spi_mosi, spi_cs_n;

   int n_chk = 0, n_fail = 0, exp_half = 1;

   always #4 clk = ~clk;

   spi_pack_master i_spi_pack_master (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be),
      .reg_rdata(reg_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_miso(spi_mosi), .spi_cs_n(spi_cs_n));

   // serial-side monitor, sampled between clock edges
   logic        p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
   logic [63:0] stream = '0;
   int tot_bits = 0, cs_rises = 0, hi_len = 0, tail_len = 0;
   int hi_err = 0, tail_err = 0, stab_err = 0, sel_err = 0;

   always @(negedge clk) begin
      if (spi_sclk && !p_sclk) begin
         stream = {stream[62:0], spi_mosi};
         tot_bits++;
      end
      if (p_sclk && spi_sclk && spi_mosi !== p_mosi) stab_err++;
      if (spi_sclk && spi_cs_n) sel_err++;
      if (spi_sclk) hi_len++;
      else if (p_sclk) begin
         if (hi_len != exp_half) hi_err++;
         hi_len = 0;
      end
      if (spi_sclk) tail_len = 0;
      else if (!spi_cs_n) tail_len++;
      if (spi_cs_n && !p_cs) begin
         cs_rises++;
         if (tail_len != exp_half) tail_err++;
         tail_len = 0;
      end
      p_sclk = spi_sclk; p_cs = spi_cs_n; p_mosi = spi_mosi;
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, input logic [1:0] be, output logic [15:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a; reg_be = be;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_sel = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (6) @(negedge clk);
      while (!spi_cs_n) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic drain();
      logic [15:0] d;
      for (int i = 0; i < 4; i++) bus_rd(4'hC, 2'b01, d);
   endtask

   // run queued frames and compare the serial stream against the expected bits
   task automatic run_and_check(input string tag, input logic [3:0] ctl1, input int nbits,
                                input logic [63:0] exp_bits, input int nsess);
      int b0, s0;
      logic [63:0] mask;
      b0 = tot_bits; s0 = cs_rises;
      bus_wr(4'h0, {12'h0, ctl1}, 2'b01);
      wait_idle();
      mask = (nbits >= 64) ? '1 : ((64'd1 << nbits) - 64'd1);
      check({tag, " clock count"}, 64'(tot_bits - b0), 64'(nbits));
      check({tag, " bit stream"}, stream & mask, exp_bits & mask);
      check({tag, " select sessions"}, 64'(cs_rises - s0), 64'(nsess));
      bus_wr(4'h0, 16'h0000, 2'b01);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] d;
      int b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 cs_n", 64'(spi_cs_n), 64'd1);
      check("R1 sclk", 64'(spi_sclk), 64'd0);
      bus_rd(4'h8, 2'b11, d); check("R1 status", 64'(d), 64'h1);
      bus_rd(4'h0, 2'b11, d); check("R1 ctrl1", 64'(d), 64'h0);
      bus_rd(4'h4, 2'b11, d); check("R1 ctrl2", 64'(d), 64'h0);

      // R11: disabled block holds frames
      b0 = tot_bits;
      bus_wr(4'hC, 16'hA55A, 2'b11);
      repeat (40) @(negedge clk);
      check("R11 no clocks while disabled", 64'(tot_bits - b0), 64'd0);
      check("R11 cs_n high while disabled", 64'(spi_cs_n), 64'd1);
      bus_rd(4'h8, 2'b01, d); check("R6 room for 8-bit frame with 2 queued", 64'(d[0]), 64'd1);

      // R2: full-width write in 8-bit mode, low byte first, back-to-back frames (R10)
      run_and_check("R2", 4'h1, 16, 64'h5AA5, 1);
      bus_rd(4'h8, 2'b01, d); check("R7 ready with two bytes, half threshold", 64'(d[1]), 64'd1);
      bus_rd(4'hC, 2'b11, d); check("R8 16-bit read", 64'(d), 64'hA55A);
      bus_rd(4'h8, 2'b01, d); check("R7 not ready when empty", 64'(d[1]), 64'd0);
      bus_rd(4'hC, 2'b11, d); check("R8 empty read returns zero", 64'(d), 64'h0);

      // R3: single low-lane write
      bus_wr(4'hC, 16'hFF3C, 2'b01);
      run_and_check("R3 low lane", 4'h1, 8, 64'h3C, 1);
      bus_rd(4'h8, 2'b01, d); check("R7 one byte, half threshold", 64'(d[1]), 64'd0);
      bus_wr(4'h4, 16'h0002, 2'b01);
      bus_rd(4'h8, 2'b01, d); check("R7 one byte, quarter threshold", 64'(d[1]), 64'd1);
      bus_rd(4'hC, 2'b01, d); check("R8 byte read low lane", 64'(d), 64'h003C);
      bus_rd(4'h8, 2'b01, d); check("R8 byte read removed one", 64'(d[1]), 64'd0);

      // R3: single high-lane write
      bus_wr(4'hC, 16'hC3EE, 2'b10);
      run_and_check("R3 high lane", 4'h1, 8, 64'hC3, 1);
      bus_rd(4'hC, 2'b10, d); check("R8 byte read high lane", 64'(d), 64'hC300);

      // R5/R6: fill queue, then overflow write dropped
      bus_wr(4'hC, 16'h2211, 2'b11);
      bus_wr(4'hC, 16'h4433, 2'b11);
      bus_rd(4'h8, 2'b01, d); check("R6 no room when full", 64'(d[0]), 64'd0);
      bus_wr(4'hC, 16'h0055, 2'b01);
      run_and_check("R5 dropped write", 4'h1, 32, 64'h11223344, 1);
      check("R5 no extra clocks", 64'(stream[39:32]), 64'hC3);
      drain();

      // R6 with three bytes queued: room for a byte, not for a word
      bus_wr(4'hC, 16'h6677, 2'b11);
      bus_wr(4'hC, 16'h0088, 2'b01);
      bus_rd(4'h8, 2'b01, d); check("R6 room one byte 8-bit", 64'(d[0]), 64'd1);
      bus_wr(4'h4, 16'h0003, 2'b01);
      bus_rd(4'h8, 2'b01, d); check("R6 no room one byte 16-bit", 64'(d[0]), 64'd0);
      bus_wr(4'h4, 16'h0002, 2'b01);
      run_and_check("R2 three queued frames", 4'h1, 24, 64'h776688, 1);
      drain();

      // R4: 16-bit frame from a single-strobe write
      bus_wr(4'h4, 16'h0001, 2'b01);
      bus_wr(4'hC, 16'h1234, 2'b01);
      run_and_check("R4 16-bit frame", 4'h1, 16, 64'h1234, 1);
      bus_rd(4'hC, 2'b11, d); check("R4 loopback word", 64'(d), 64'h1234);
      bus_wr(4'hC, 16'hBEEF, 2'b11);
      bus_wr(4'hC, 16'h0F0F, 2'b10);
      run_and_check("R4 two 16-bit frames", 4'h1, 32, 64'hBEEF0F0F, 1);
      drain();

      // R9/R10: slower clock, exponent 2 gives four-cycle half periods
      bus_wr(4'h4, 16'h0000, 2'b01);
      exp_half = 4;
      bus_wr(4'hC, 16'h0081, 2'b01);
      run_and_check("R9 divided clock", 4'h5, 8, 64'h81, 1);
      drain();
      exp_half = 2;
      for (int v = 0; v < 4; v++) bus_wr(4'hC, 16'(8'(v * 37 + 5)), 2'b01);
      run_and_check("R9 exponent one", 4'h3, 32,
                    {32'h0, 8'd5, 8'd42, 8'd79, 8'd116}, 1);
      drain();

      check("R9 high half-period length", 64'(hi_err), 64'd0);
      check("R9 data stable while clock high", 64'(stab_err), 64'd0);
      check("R10 release one half period after last edge", 64'(tail_err), 64'd0);
      check("R10 clock only inside select", 64'(sel_err), 64'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule